// File: doc/BRIEF.md
# PLL Divider Parameter Solver

This block turns a requested clock period into settings for a frequency synthesizer. A start pulse presents a reference clock period, a reference divider value and a target period. From these the block forms an integer ratio and checks that the ratio lies in the usable range. It then picks a post-divider code by comparing the ratio against fixed thresholds and derives the feedback divider from the ratio and the real divide factor for that code.

It also fills in a control byte. The low bits of that byte carry a fixed enable pattern. A two-bit field counts how many times a precomputed synthesizer output frequency, divided by the post factor, has to be halved to stay under a scaler limit. The halving stops after two steps. A limit of zero switches the halving off.

The ratio is produced by a restoring divider, one quotient bit per cycle, so the result appears a fixed number of cycles after the start. A controller issues one request at a time and waits for the single-cycle done pulse. Results stay on the outputs until the next request finishes.

Top module: `pll_div_solver`

## Requirements
- R1: The ratio q is floor(ref_per_i × ref_div_i × 4 / tgt_per_i), taken over the full product width.
- R2: If q < 128 or q > 2040, err_o is 1 and post_code_o, post_fact_o, fb_div_o and ctrl_o are all 0. A target period of 0 counts as out of range.
- R3: For a valid q, post_code_o is the number of true comparisons among q < 1024, q < 512 and q < 256, so it ranges from 0 to 3.
- R4: post_fact_o is the real divide factor for the code: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8.
- R5: For a valid q, fb_div_o is floor(q × post_fact_o / 8), which always lies in 128..255.
- R6: For a valid q, ctrl_o bits [1:0] are 2'b11, bits [3:2] and [7:6] are 0, and bits [5:4] hold the halving count from R7.
- R7: The halving count works on f = pll_freq_i >> post_code_o. With scale_max_i nonzero, f is halved while f > scale_max_i, at most twice, and the count is the number of halvings (0..2). With scale_max_i equal to 0 the count is 0.
- R8: done_o is high for exactly one cycle, 27 cycles after the cycle in which an accepted start_i is sampled (with default widths, the product width plus one).
- R9: A start_i pulse that arrives while a calculation is running is ignored. A start_i in the same cycle as done_o is accepted as a new request.
- R10: err_o goes to 0 in the cycle after an accepted start. The divider outputs and ctrl_o change only together with a done_o pulse and hold their values otherwise.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse |
| ref_per_i | input | 16 | Reference clock period |
| ref_div_i | input | 8 | Reference divider |
| tgt_per_i | input | 16 | Target clock period |
| scale_max_i | input | 16 | Scaler frequency limit, 0 disables halving |
| pll_freq_i | input | 16 | Precomputed synthesizer output frequency |
| post_code_o | output | 3 | Post-divider code |
| post_fact_o | output | 4 | Real post-divide factor |
| fb_div_o | output | 8 | Feedback divider |
| ctrl_o | output | 8 | Control byte |
| err_o | output | 1 | Ratio out of range |
| done_o | output | 1 | Result valid, one cycle |

## Verification
The collision that matters is a new start_i arriving in the same cycle as the done_o pulse of the previous request. Two things happen on that edge: the finished result is presented, and err_o is cleared for the new request. The bench waits for done_o and raises start_i in that same cycle, right after an out-of-range request. The scoreboard checks that the finished error result is the one shown during the done cycle, that err_o reads 0 one cycle later, and that the second result arrives exactly on schedule. A separate start pulse placed in the middle of a running calculation must leave no second result and no change to the first one.

// File: rtl/pll_solve_pkg.sv
package pll_solve_pkg;
  localparam int FB_W      = 8;
  localparam int POST_W    = 3;
  localparam int FACT_W    = 4;
  localparam int MAX_HALVE = 2;
  localparam int HALVE_W   = 2;
  localparam int CTRL_W    = 8;
  localparam int HALVE_LSB = 4;
  localparam int FRAC_SH   = 3;
  localparam int N_THR     = 3;
  localparam logic [CTRL_W-1:0] CTRL_BASE = 8'h03;

  typedef enum logic [0:0] {ST_IDLE, ST_RUN} state_e;

  // code 4 is the odd divide-by-3 entry
  function automatic logic [FACT_W-1:0] post_factor(input logic [POST_W-1:0] code);
    case (code)
      3'd0:    post_factor = 4'd1;
      3'd1:    post_factor = 4'd2;
      3'd2:    post_factor = 4'd4;
      3'd3:    post_factor = 4'd8;
      3'd4:    post_factor = 4'd3;
      default: post_factor = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/pll_solve_div.sv
module pll_solve_div #(
  parameter int NUM_W = 26,
  parameter int DEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quo_o,
  output logic             done_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W:0]   rem_q;
  logic [NUM_W-1:0] quo_q;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q;
  logic [DEN_W:0]   rem_sh;
  logic [DEN_W+1:0] trial;

  always_comb begin
    rem_sh = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
    trial  = {1'b0, rem_sh} - {2'b00, den_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (load_i) begin
      rem_q  <= '0;
      quo_q  <= num_i;
      den_q  <= den_i;
      cnt_q  <= CNT_W'(NUM_W);
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (run_q) begin
      if (!trial[DEN_W+1]) begin
        rem_q <= trial[DEN_W:0];
        quo_q <= {quo_q[NUM_W-2:0], 1'b1};
      end else begin
        rem_q <= rem_sh;
        quo_q <= {quo_q[NUM_W-2:0], 1'b0};
      end
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign quo_o  = quo_q;
  assign done_o = done_q;
endmodule

// File: rtl/pll_solve_post.sv
module pll_solve_post
  import pll_solve_pkg::*;
#(
  parameter int Q_W = 26
) (
  input  logic [Q_W-1:0]    q_i,
  output logic              err_o,
  output logic [POST_W-1:0] code_o,
  output logic [FACT_W-1:0] fact_o,
  output logic [FB_W-1:0]   fb_o
);
  localparam int Q_MIN = 2 ** (FB_W - 1);
  localparam int Q_MAX = (2 ** FB_W - 1) << FRAC_SH;
  localparam int P_W   = Q_W + FACT_W;

  logic [N_THR-1:0]  below;
  logic [POST_W-1:0] code;
  logic [FACT_W-1:0] fact;
  logic [P_W-1:0]    prod;

  for (genvar i = 0; i < N_THR; i++) begin : g_thr
    assign below[i] = q_i < Q_W'(Q_MIN << (i + 1));
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < N_THR; i++) code = code + POST_W'(below[i]);
    fact  = post_factor(code);
    prod  = P_W'(q_i) * P_W'(fact);
    err_o = (q_i < Q_W'(Q_MIN)) || (q_i > Q_W'(Q_MAX));
    if (err_o) begin
      code_o = '0;
      fact_o = '0;
      fb_o   = '0;
    end else begin
      code_o = code;
      fact_o = fact;
      fb_o   = prod[FB_W+FRAC_SH-1:FRAC_SH];
    end
  end
endmodule

// File: rtl/pll_solve_scale.sv
module pll_solve_scale
  import pll_solve_pkg::*;
#(
  parameter int FREQ_W = 16
) (
  input  logic [FREQ_W-1:0]  freq_i,
  input  logic [POST_W-1:0]  code_i,
  input  logic [FREQ_W-1:0]  limit_i,
  output logic [HALVE_W-1:0] halve_o
);
  logic [FREQ_W-1:0]    f [MAX_HALVE+1];
  logic [MAX_HALVE-1:0] over;

  assign f[0] = freq_i >> code_i;

  for (genvar s = 0; s < MAX_HALVE; s++) begin : g_stage
    assign over[s]  = (limit_i != '0) && (f[s] > limit_i);
    assign f[s+1]   = over[s] ? (f[s] >> 1) : f[s];
  end

  always_comb begin
    halve_o = '0;
    for (int s = 0; s < MAX_HALVE; s++) halve_o = halve_o + HALVE_W'(over[s]);
  end
endmodule

// File: rtl/pll_div_solver.sv
module pll_div_solver
  import pll_solve_pkg::*;
#(
  parameter int PER_W  = 16,
  parameter int RDIV_W = 8,
  parameter int FREQ_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PER_W-1:0]  ref_per_i,
  input  logic [RDIV_W-1:0] ref_div_i,
  input  logic [PER_W-1:0]  tgt_per_i,
  input  logic [FREQ_W-1:0] scale_max_i,
  input  logic [FREQ_W-1:0] pll_freq_i,
  output logic [POST_W-1:0] post_code_o,
  output logic [FACT_W-1:0] post_fact_o,
  output logic [FB_W-1:0]   fb_div_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              err_o,
  output logic              done_o
);
  localparam int NUM_W = PER_W + RDIV_W + 2;

  state_e            state_q;
  logic              accept;
  logic [NUM_W-1:0]  num;
  logic [NUM_W-1:0]  quo;
  logic              div_done;
  logic [FREQ_W-1:0] freq_q, lim_q;
  logic              p_err;
  logic [POST_W-1:0] p_code;
  logic [FACT_W-1:0] p_fact;
  logic [FB_W-1:0]   p_fb;
  logic [HALVE_W-1:0] halve;
  logic [CTRL_W-1:0] ctrl_n;

  assign accept = start_i && (state_q == ST_IDLE);
  assign num    = (NUM_W'(ref_per_i) * NUM_W'(ref_div_i)) << 2;

  pll_solve_div #(.NUM_W(NUM_W), .DEN_W(PER_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .num_i  (num),
    .den_i  (tgt_per_i),
    .quo_o  (quo),
    .done_o (div_done)
  );

  pll_solve_post #(.Q_W(NUM_W)) u_post (
    .q_i    (quo),
    .err_o  (p_err),
    .code_o (p_code),
    .fact_o (p_fact),
    .fb_o   (p_fb)
  );

  pll_solve_scale #(.FREQ_W(FREQ_W)) u_scale (
    .freq_i  (freq_q),
    .code_i  (p_code),
    .limit_i (lim_q),
    .halve_o (halve)
  );

  assign ctrl_n = p_err ? '0 : (CTRL_BASE | (CTRL_W'(halve) << HALVE_LSB));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      freq_q      <= '0;
      lim_q       <= '0;
      post_code_o <= '0;
      post_fact_o <= '0;
      fb_div_o    <= '0;
      ctrl_o      <= '0;
      err_o       <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        state_q <= ST_RUN;
        freq_q  <= pll_freq_i;
        lim_q   <= scale_max_i;
        err_o   <= 1'b0;
      end else if (state_q == ST_RUN && div_done) begin
        state_q     <= ST_IDLE;
        post_code_o <= p_code;
        post_fact_o <= p_fact;
        fb_div_o    <= p_fb;
        ctrl_o      <= ctrl_n;
        err_o       <= p_err;
        done_o      <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_div_solver_chk.sv
module pll_div_solver_chk
  import pll_solve_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [POST_W-1:0] post_code_o,
  input logic [FACT_W-1:0] post_fact_o,
  input logic [FB_W-1:0]   fb_div_o,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              err_o,
  input logic              done_o
);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_err_blank_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (post_code_o == '0 && post_fact_o == '0 && fb_div_o == '0 && ctrl_o == '0));

  assert_fb_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> fb_div_o[FB_W-1]);

  assert_fact_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (post_code_o <= 3'd3 && $countones(post_fact_o) == 1
                            && post_fact_o == (FACT_W'(1) << post_code_o)));

  assert_ctrl_shape_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (ctrl_o[1:0] == 2'b11 && ctrl_o[3:2] == 2'b00
                            && ctrl_o[7:6] == 2'b00 && ctrl_o[5:4] != 2'b11));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(fb_div_o) && $stable(post_code_o) && $stable(post_fact_o)
                 && $stable(ctrl_o)));
endmodule

bind pll_div_solver pll_div_solver_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .post_code_o (post_code_o),
  .post_fact_o (post_fact_o),
  .fb_div_o    (fb_div_o),
  .ctrl_o      (ctrl_o),
  .err_o       (err_o),
  .done_o      (done_o)
);

// File: tb/pll_div_solver_tb.sv
module pll_div_solver_tb;
  localparam int LAT = 28;  // posedge count from drive negedge to done negedge (R8)

  typedef struct {
    logic [2:0]  code;
    logic [3:0]  fact;
    logic [7:0]  fb;
    logic [7:0]  ctrl;
    logic        err;
    int          due;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] ref_per_i = '0, tgt_per_i = '0, scale_max_i = '0, pll_freq_i = '0;
  logic [7:0]  ref_div_i = '0;
  logic [2:0]  post_code_o;
  logic [3:0]  post_fact_o;
  logic [7:0]  fb_div_o, ctrl_o;
  logic        err_o, done_o;

  int   n_chk = 0, n_fail = 0, cyc = 0;
  bit   have_last = 0, ended = 0;
  exp_t exp_q[$];
  exp_t last;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pll_div_solver u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .ref_per_i(ref_per_i),
    .ref_div_i(ref_div_i), .tgt_per_i(tgt_per_i), .scale_max_i(scale_max_i),
    .pll_freq_i(pll_freq_i), .post_code_o(post_code_o), .post_fact_o(post_fact_o),
    .fb_div_o(fb_div_o), .ctrl_o(ctrl_o), .err_o(err_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input longint rp, input longint rd, input longint tp,
                                 input longint lim, input longint fr, input string tag);
    exp_t e;
    longint q, f;
    int code, fact, h;
    e.tag = tag; e.code = 0; e.fact = 0; e.fb = 0; e.ctrl = 0; e.err = 1; e.due = 0;
    q = (tp == 0) ? 64'h7fffffff : (rp * rd * 4) / tp;       // R1
    if (q < 128 || q > 2040) return e;                        // R2
    code = 0;
    if (q < 1024) code++;
    if (q < 512)  code++;
    if (q < 256)  code++;                                     // R3
    fact = 1 << code;                                         // R4
    f = fr / fact;
    h = 0;
    while (lim != 0 && f > lim && h < 2) begin f = f / 2; h++; end  // R7
    e.err = 0; e.code = 3'(code); e.fact = 4'(fact);
    e.fb = 8'((q * fact) / 8);                                // R5
    e.ctrl = 8'h03 | 8'(h << 4);                              // R6
    return e;
  endfunction

  // caller is at a negedge
  task automatic launch(input int rp, input int rd, input int tp, input int lim, input int fr,
                        input string tag);
    exp_t e;
    e = model(rp, rd, tp, lim, fr, tag);
    e.due = cyc + LAT;
    exp_q.push_back(e);
    ref_per_i = 16'(rp); ref_div_i = 8'(rd); tgt_per_i = 16'(tp);
    scale_max_i = 16'(lim); pll_freq_i = 16'(fr); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(err_o == 1'b0, "R10", "err cleared after start", err_o, 0);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done_o);
  endtask

  task automatic run(input int rp, input int rd, input int tp, input int lim, input int fr,
                     input string tag);
    @(negedge clk);
    launch(rp, rd, tp, lim, fr, tag);
    wait_done();
  endtask

  // monitor: scoreboard and hold check
  always @(negedge clk) begin
    if (rst_ni && !ended) begin
      if (done_o) begin
        if (exp_q.size() == 0) begin
          chk(0, "R9", "unexpected done", 1, 0);
        end else begin
          last = exp_q.pop_front();
          have_last = 1;
          chk(cyc == last.due,           "R8", "done cycle", cyc, last.due);
          chk(err_o == last.err,         last.tag, "err", err_o, last.err);
          chk(post_code_o == last.code,  last.tag, "post code", post_code_o, last.code);
          chk(post_fact_o == last.fact,  last.tag, "post factor", post_fact_o, last.fact);
          chk(fb_div_o == last.fb,       last.tag, "fb div", fb_div_o, last.fb);
          chk(ctrl_o == last.ctrl,       last.tag, "ctrl", ctrl_o, last.ctrl);
        end
      end else if (have_last) begin
        chk(fb_div_o == last.fb && post_code_o == last.code && ctrl_o == last.ctrl
            && post_fact_o == last.fact, "R10", "hold fb", fb_div_o, last.fb);
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(post_code_o == 0 && post_fact_o == 0 && fb_div_o == 0 && ctrl_o == 0
        && err_o == 0 && done_o == 0, "R11", "reset outputs", fb_div_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(done_o == 0 && err_o == 0, "R11", "idle after reset", done_o, 0);

    run(1000, 1, 2,  0, 1000, "R3");    // q=2000 code0
    run(1000, 1, 5,  0, 1000, "R4");    // q=800 code1
    run(1000, 1, 10, 0, 1000, "R5");    // q=400 code2
    run(1000, 1, 20, 0, 1000, "R3");    // q=200 code3
    run(1000, 1, 40, 0, 1000, "R2");    // q=100 low
    run(1000, 1, 1,  0, 1000, "R2");    // q=4000 high
    run(1000, 3, 0,  0, 1000, "R2");    // zero target
    run(32,   1, 1,  0, 100,  "R1");    // q=128 edge
    run(510,  1, 1,  0, 100,  "R1");    // q=2040 edge
    run(127,  1, 4,  0, 100,  "R2");    // q=127
    run(1531, 1, 3,  0, 100,  "R2");    // q=2041
    run(1023, 1, 4,  0, 100,  "R3");    // q=1023
    run(256,  1, 1,  0, 100,  "R3");    // q=1024
    run(300,  7, 9,  0, 100,  "R1");    // q=933
    run(1000, 1, 5,  0,   1000, "R7");  // limit zero
    run(1000, 1, 5,  600, 1000, "R7");  // no halving
    run(1000, 1, 5,  300, 1000, "R7");  // one halving
    run(1000, 1, 5,  100, 1000, "R7");  // capped at two
    run(1000, 1, 20, 20,  1000, "R6");  // code3, f=125 -> 2

    // R9: start during busy is ignored
    @(negedge clk);
    launch(1000, 1, 10, 50, 2000, "R9");
    repeat (5) @(negedge clk);
    ref_per_i = 16'd9; tgt_per_i = 16'd1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    repeat (LAT + 5) @(negedge clk);

    // R9/R10: error result then new start in the done cycle
    @(negedge clk);
    launch(1000, 1, 1, 0, 1000, "R2");
    wait_done();
    launch(1000, 1, 2, 0, 1000, "R9");
    wait_done();
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule